// File: doc/BRIEF.md
# Flash read mode and standby controller

This block sits between a word-organised memory array and the read bus of a chip and decides how words leave the array. Two read modes exist. In the asynchronous mode, which is the mode after reset, the word at the presented address appears on the data output one clock later. In the synchronous burst mode, a start pulse captures a start address. After a fixed first-access latency, the block delivers one word on every clock, and a hold input can pause the stream without losing its place. A configuration command switches between the modes and selects the burst length: four words, eight words or continuous.

During asynchronous operation, a monitor watches the address and chip-enable inputs. When both stay unchanged for a parameterised number of clocks, the block enters standby and raises its standby indicator. The data output stays driven with the last word throughout. The next change of address or chip enable brings the block out of standby. The array is a plain register model with its own write port, which is used to load contents.

The controller is built around one state machine with six named states:
- ASYNC_ACTIVE and ASYNC_STANDBY serve the asynchronous mode.
- SYNC_IDLE, SYNC_LATENCY, SYNC_BURST and SYNC_SUSPEND serve the burst mode.

The transitions are:
- A configuration command moves to ASYNC_ACTIVE or SYNC_IDLE, whichever mode it selects.
- ASYNC_ACTIVE goes to ASYNC_STANDBY when the idle count expires.
- ASYNC_STANDBY goes back to ASYNC_ACTIVE on an address or chip-enable change.
- An accepted start goes to SYNC_LATENCY, or directly to SYNC_BURST when the latency is one clock.
- SYNC_LATENCY goes to SYNC_BURST when the latency count is complete.
- SYNC_BURST goes to SYNC_SUSPEND when hold is high.
- SYNC_SUSPEND goes back to SYNC_BURST when hold is released.
- SYNC_BURST or SYNC_SUSPEND goes to SYNC_IDLE after the last word of a fixed-length burst.
- Any synchronous state goes to SYNC_IDLE when chip enable falls.

Top module: `flash_read_ctrl`

## Requirements
- R1: Reset leaves the block in asynchronous mode, with the burst length set to four, `rvalid` at 0, `rdata` at 0 and `standby` at 0.
- R2: In asynchronous mode with `chip_en` high, the edge that samples `addr` loads the array word at that address into `rdata` and sets `rvalid` to 1. With `chip_en` low, `rvalid` is 0 and `rdata` keeps its value.
- R3: In asynchronous mode, `standby` rises on the IDLE_CYCLES-th edge after the last edge at which `addr` or `chip_en` differed from its previously sampled value.
- R4: While `standby` is 1, `rdata` does not change, even when the array word at the current address is rewritten.
- R5: The first edge that samples a changed `addr` or `chip_en` in standby clears `standby`. If `chip_en` is then high, the same edge loads the word at the new address.
- R6: A `cfg_wr` pulse selects synchronous mode when `cfg_sync`=1 and asynchronous mode when `cfg_sync`=0. It latches the burst length from `cfg_len`: 2'b00 selects four words, 2'b01 selects eight words, and 2'b10 or 2'b11 selects continuous.
- R7: For a burst of N words (N=4 or 8) starting at address s, word k comes from address (s with its low log2(N) bits replaced by (s+k) mod N).
- R8: In synchronous mode, a start pulse with `chip_en` high is accepted on the edge that samples it, and a start also restarts a running burst. The first word appears on the LATENCY-th edge after that edge, and `rvalid` is 0 on every edge before it.
- R9: In continuous mode, word k comes from address (s+k) mod 2^AW, and the stream runs until it is stopped.
- R10: Every edge in the burst phase that samples `hold`=1 emits no word: `rvalid` is 0, `rdata` holds, and the next word after release is the one that was due. `hold` has no effect during the latency phase.
- R11: Burst words appear on consecutive edges while `hold` is low. A fixed-length burst ends after N words, with `rvalid` returning to 0 on the following edge.
- R12: `standby` stays 0 in synchronous mode, however long the inputs stay idle.
- R13: `chip_en` low in synchronous mode ends any latency or burst, and `rvalid` is 0 from the next edge.
- R14: A reset while in synchronous mode returns the block to asynchronous reads, with no configuration command needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also serves as the burst clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chip_en | input | 1 | Chip enable, active high |
| addr | input | AW | Read address (asynchronous) or burst start address |
| start | input | 1 | Burst start pulse (synchronous mode only) |
| hold | input | 1 | Pauses a running burst while high |
| cfg_wr | input | 1 | Configuration command strobe |
| cfg_sync | input | 1 | Mode selected by the command: 1 synchronous, 0 asynchronous |
| cfg_len | input | 2 | Burst length selected by the command |
| load_en | input | 1 | Array model write enable |
| load_addr | input | AW | Array model write address |
| load_data | input | DW | Array model write data |
| rdata | output | DW | Read data, always driven |
| rvalid | output | 1 | A word was delivered by the last edge |
| standby | output | 1 | Automatic standby is active |

## Verification
The bench sweeps every start address for both fixed burst lengths, so that every wrap position inside a four-word and an eight-word group is visited. A wrong wrap rule would show up as a word taken from outside the group, or from the next group. The standby count is checked on each edge up to expiry: a counter that is off by one raises `standby` one edge early or one edge late. A rewrite of the addressed word during standby would leak onto `rdata` if the block kept reading the array.

Hold is applied during the latency phase and in the middle of a burst. A design that sampled hold in the latency phase would delay the first word. A design that advanced the address during suspend would skip a word on resume. Continuous mode is run across the top of the address space and then aborted with chip enable, and a reset is applied mid-burst to check the return to asynchronous reads.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

    typedef enum logic [2:0] {
        ST_ASYNC_ACTIVE,
        ST_ASYNC_STANDBY,
        ST_SYNC_IDLE,
        ST_SYNC_LATENCY,
        ST_SYNC_BURST,
        ST_SYNC_SUSPEND
    } rd_state_e;

    typedef enum logic [1:0] {
        BL_FOUR  = 2'b00,
        BL_EIGHT = 2'b01,
        BL_CONT  = 2'b10
    } burst_len_e;

    // Command encoding: 00 -> four words, 01 -> eight words, 1x -> continuous
    function automatic burst_len_e decode_len(input logic [1:0] code);
        if (code[1])
            return BL_CONT;
        else if (code[0])
            return BL_EIGHT;
        else
            return BL_FOUR;
    endfunction

endpackage

// File: rtl/frc_array.sv
module frc_array #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem_q[wr_addr] <= wr_data;
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/frc_idle_mon.sv
module frc_idle_mon #(
    parameter int AW          = 6,
    parameter int IDLE_CYCLES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [AW-1:0] addr,
    input  logic          chip_en,
    output logic          changed,
    output logic          idle_hit
);
    localparam int CW = $clog2(IDLE_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYCLES - 1);

    logic [AW-1:0] prev_addr_q;
    logic          prev_ce_q;
    logic [CW-1:0] cnt_q;

    assign changed  = (addr != prev_addr_q) || (chip_en != prev_ce_q);
    assign idle_hit = !changed && (cnt_q == LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_addr_q <= '0;
            prev_ce_q   <= 1'b0;
        end else begin
            prev_addr_q <= addr;
            prev_ce_q   <= chip_en;
        end
    end

    // Saturating count of unchanged edges
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr || changed)
            cnt_q <= '0;
        else if (cnt_q != LIMIT)
            cnt_q <= cnt_q + CW'(1);
    end

endmodule

// File: rtl/frc_burst_seq.sv
module frc_burst_seq
    import flash_rd_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  burst_len_e    len,
    input  logic          advance,
    output logic [AW-1:0] cur_addr,
    output logic          last_word
);
    logic [AW-1:0] cur_q;
    logic [AW-1:0] nxt;
    logic [2:0]    wcnt_q;

    always_comb begin
        unique case (len)
            BL_FOUR:  nxt = {cur_q[AW-1:2], cur_q[1:0] + 2'd1};
            BL_EIGHT: nxt = {cur_q[AW-1:3], cur_q[2:0] + 3'd1};
            default:  nxt = cur_q + AW'(1);
        endcase
    end

    assign last_word = ((len == BL_FOUR)  && (wcnt_q == 3'd3)) ||
                       ((len == BL_EIGHT) && (wcnt_q == 3'd7));
    assign cur_addr  = cur_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            wcnt_q <= '0;
        end else if (load) begin
            cur_q  <= base;
            wcnt_q <= '0;
        end else if (advance) begin
            cur_q  <= nxt;
            wcnt_q <= wcnt_q + 3'd1;
        end
    end

endmodule

// File: rtl/flash_read_ctrl.sv
module flash_read_ctrl
    import flash_rd_pkg::*;
#(
    parameter int AW          = 6,
    parameter int DW          = 16,
    parameter int LATENCY     = 4,
    parameter int IDLE_CYCLES = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chip_en,
    input  logic [AW-1:0] addr,
    input  logic          start,
    input  logic          hold,
    input  logic          cfg_wr,
    input  logic          cfg_sync,
    input  logic [1:0]    cfg_len,
    input  logic          load_en,
    input  logic [AW-1:0] load_addr,
    input  logic [DW-1:0] load_data,
    output logic [DW-1:0] rdata,
    output logic          rvalid,
    output logic          standby
);
    localparam int LW = $clog2(LATENCY + 1);
    localparam logic [LW-1:0] LAT_LAST = LW'(LATENCY - 1);

    rd_state_e     st_q, st_d;
    rd_state_e     first_phase;
    logic          sync_q;
    burst_len_e    len_q;
    logic [LW-1:0] lat_q;
    logic          changed, idle_hit;
    logic          seq_load, emit, last_word;
    logic          in_sync_st, in_burst_st;
    logic [AW-1:0] seq_addr, rd_addr;
    logic [DW-1:0] arr_rd;

    frc_array #(.AW(AW), .DW(DW)) u_array (
        .clk     (clk),
        .wr_en   (load_en),
        .wr_addr (load_addr),
        .wr_data (load_data),
        .rd_addr (rd_addr),
        .rd_data (arr_rd)
    );

    frc_idle_mon #(.AW(AW), .IDLE_CYCLES(IDLE_CYCLES)) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cfg_wr),
        .addr     (addr),
        .chip_en  (chip_en),
        .changed  (changed),
        .idle_hit (idle_hit)
    );

    frc_burst_seq #(.AW(AW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (seq_load),
        .base      (addr),
        .len       (len_q),
        .advance   (emit),
        .cur_addr  (seq_addr),
        .last_word (last_word)
    );

    assign in_sync_st  = (st_q == ST_SYNC_IDLE) || (st_q == ST_SYNC_LATENCY) ||
                         (st_q == ST_SYNC_BURST) || (st_q == ST_SYNC_SUSPEND);
    assign in_burst_st = (st_q == ST_SYNC_BURST) || (st_q == ST_SYNC_SUSPEND);
    assign seq_load    = !cfg_wr && in_sync_st && chip_en && start;
    assign emit        = !cfg_wr && in_burst_st && chip_en && !start && !hold;
    assign rd_addr     = sync_q ? seq_addr : addr;
    assign first_phase = (LATENCY <= 1) ? ST_SYNC_BURST : ST_SYNC_LATENCY;
    assign standby     = (st_q == ST_ASYNC_STANDBY);

    // Configuration register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 1'b0;
            len_q  <= BL_FOUR;
        end else if (cfg_wr) begin
            sync_q <= cfg_sync;
            len_q  <= decode_len(cfg_len);
        end
    end

    // First-access latency counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lat_q <= '0;
        else if (seq_load)
            lat_q <= LW'(1);
        else if (st_q == ST_SYNC_LATENCY)
            lat_q <= lat_q + LW'(1);
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            st_d = cfg_sync ? ST_SYNC_IDLE : ST_ASYNC_ACTIVE;
        end else begin
            unique case (st_q)
                ST_ASYNC_ACTIVE: begin
                    if (idle_hit)
                        st_d = ST_ASYNC_STANDBY;
                end
                ST_ASYNC_STANDBY: begin
                    if (changed)
                        st_d = ST_ASYNC_ACTIVE;
                end
                ST_SYNC_IDLE: begin
                    if (chip_en && start)
                        st_d = first_phase;
                end
                ST_SYNC_LATENCY: begin
                    if (!chip_en)
                        st_d = ST_SYNC_IDLE;
                    else if (start)
                        st_d = first_phase;
                    else if (lat_q == LAT_LAST)
                        st_d = ST_SYNC_BURST;
                end
                ST_SYNC_BURST: begin
                    if (!chip_en)
                        st_d = ST_SYNC_IDLE;
                    else if (start)
                        st_d = first_phase;
                    else if (hold)
                        st_d = ST_SYNC_SUSPEND;
                    else if (last_word)
                        st_d = ST_SYNC_IDLE;
                end
                ST_SYNC_SUSPEND: begin
                    if (!chip_en)
                        st_d = ST_SYNC_IDLE;
                    else if (start)
                        st_d = first_phase;
                    else if (!hold)
                        st_d = last_word ? ST_SYNC_IDLE : ST_SYNC_BURST;
                end
                default: st_d = ST_ASYNC_ACTIVE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_ASYNC_ACTIVE;
        else
            st_q <= st_d;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else if (cfg_wr) begin
            rvalid <= 1'b0;
        end else begin
            unique case (st_q)
                ST_ASYNC_ACTIVE: begin
                    rvalid <= chip_en;
                    if (chip_en)
                        rdata <= arr_rd;
                end
                ST_ASYNC_STANDBY: begin
                    if (changed) begin
                        rvalid <= chip_en;
                        if (chip_en)
                            rdata <= arr_rd;
                    end
                end
                ST_SYNC_IDLE, ST_SYNC_LATENCY,
                ST_SYNC_BURST, ST_SYNC_SUSPEND: begin
                    rvalid <= emit;
                    if (emit)
                        rdata <= arr_rd;
                end
                default: rvalid <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/frc_checker.sv
module frc_checker #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          chip_en,
    input logic [AW-1:0] addr,
    input logic          start,
    input logic          hold,
    input logic          cfg_wr,
    input logic [DW-1:0] rdata,
    input logic          rvalid,
    input logic          standby,
    input logic          sync_mode,
    input logic          in_burst
);

    // R1: reset clears the outputs
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!rvalid && !standby));

    // R4: data output frozen across standby
    assert_standby_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && $past(standby)) |-> $stable(rdata));

    // R5: an input change leaves standby
    assert_standby_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (standby && ((addr != $past(addr)) || (chip_en != $past(chip_en)))) |=> !standby);

    // R12: standby never while in synchronous mode
    assert_no_sync_standby_R12: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> !sync_mode);

    // R10: a held burst emits nothing
    assert_hold_suspends_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_burst && hold && chip_en && !start && !cfg_wr) |=> !rvalid);

    // R8: an accepted start is never followed at once by a word
    assert_start_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && chip_en && start && !cfg_wr) |=> !rvalid);

    // R13: chip enable low in synchronous mode stops delivery
    assert_ce_abort_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && !chip_en && !cfg_wr) |=> !rvalid);

endmodule

bind flash_read_ctrl frc_checker #(.AW(AW), .DW(DW)) i_frc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .chip_en   (chip_en),
    .addr      (addr),
    .start     (start),
    .hold      (hold),
    .cfg_wr    (cfg_wr),
    .rdata     (rdata),
    .rvalid    (rvalid),
    .standby   (standby),
    .sync_mode (sync_q),
    .in_burst  ((st_q == flash_rd_pkg::ST_SYNC_BURST) || (st_q == flash_rd_pkg::ST_SYNC_SUSPEND))
);

// File: tb/test_flash_read_ctrl.sv
`timescale 1ns/1ps
module test_flash_read_ctrl;
    localparam int AW   = 5;
    localparam int DW   = 16;
    localparam int LAT  = 3;
    localparam int IDLE = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chip_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          start = 1'b0;
    logic          hold = 1'b0;
    logic          cfg_wr = 1'b0;
    logic          cfg_sync = 1'b0;
    logic [1:0]    cfg_len = 2'b00;
    logic          load_en = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic [DW-1:0] load_data = '0;
    logic [DW-1:0] rdata;
    logic          rvalid;
    logic          standby;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    flash_read_ctrl #(.AW(AW), .DW(DW), .LATENCY(LAT), .IDLE_CYCLES(IDLE)) i_flash_read_ctrl (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .addr(addr), .start(start),
        .hold(hold), .cfg_wr(cfg_wr), .cfg_sync(cfg_sync), .cfg_len(cfg_len),
        .load_en(load_en), .load_addr(load_addr), .load_data(load_data),
        .rdata(rdata), .rvalid(rvalid), .standby(standby)
    );

    function automatic logic [DW-1:0] dval(input int a);
        return DW'(16'h5A00 ^ (a * 97));
    endfunction

    function automatic int exp_addr(input int s, input int k, input int code);
        if (code == 0) return (s & ~3) | ((s + k) & 3);
        if (code == 1) return (s & ~7) | ((s + k) & 7);
        return (s + k) % DEPTH;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic write_word(input int a, input logic [DW-1:0] d);
        load_en = 1'b1; load_addr = AW'(a); load_data = d;
        tick();
        load_en = 1'b0;
    endtask

    task automatic configure(input bit sy, input logic [1:0] len);
        cfg_wr = 1'b1; cfg_sync = sy; cfg_len = len;
        tick();
        cfg_wr = 1'b0;
    endtask

    task automatic run_burst(input int s, input int code, input int nw, input int hold_at,
                             input int hold_len, input bit lat_hold, input bit cont);
        logic [DW-1:0] last;
        addr = AW'(s); chip_en = 1'b1; start = 1'b1;
        tick();
        start = 1'b0;
        if (lat_hold) hold = 1'b1;
        for (int e = 1; e < LAT; e++) begin
            tick();
            chk(rvalid == 1'b0, "R8 latency gap", rvalid, 0);
        end
        hold = 1'b0;
        last = rdata;
        for (int k = 0; k < nw; k++) begin
            if (k == hold_at) begin
                for (int h = 0; h < hold_len; h++) begin
                    hold = 1'b1;
                    tick();
                    chk(rvalid == 1'b0, "R10 hold rvalid", rvalid, 0);
                    chk(rdata == last, "R10 hold rdata", rdata, last);
                end
                hold = 1'b0;
            end
            tick();
            chk(rvalid == 1'b1, "R11 word valid", rvalid, 1);
            chk(rdata == dval(exp_addr(s, k, code)),
                (code == 2) ? "R9 continuous word" : "R7 wrapped word",
                rdata, dval(exp_addr(s, k, code)));
            last = rdata;
        end
        if (!cont) begin
            tick();
            chk(rvalid == 1'b0, "R11 burst end", rvalid, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(rdata == '0, "R1 rdata", rdata, 0);
        chk(rvalid == 1'b0, "R1 rvalid", rvalid, 0);
        chk(standby == 1'b0, "R1 standby", standby, 0);

        for (int a = 0; a < DEPTH; a++) write_word(a, dval(a));

        // Asynchronous sweep
        for (int a = 0; a < DEPTH; a++) begin
            addr = AW'(a); chip_en = 1'b1;
            tick();
            chk(rdata == dval(a), "R2 async data", rdata, dval(a));
            chk(rvalid == 1'b1, "R2 async rvalid", rvalid, 1);
        end

        // Standby entry count
        for (int j = 1; j <= IDLE; j++) begin
            tick();
            chk(standby == (j == IDLE), "R3 standby timing", standby, (j == IDLE));
        end

        // Rewrite current word during standby
        write_word(DEPTH - 1, 16'hFFFF);
        tick();
        chk(standby == 1'b1, "R4 still standby", standby, 1);
        chk(rdata == dval(DEPTH - 1), "R4 held data", rdata, dval(DEPTH - 1));

        // Exit on address change
        addr = AW'(5);
        tick();
        chk(standby == 1'b0, "R5 exit on addr", standby, 0);
        chk(rdata == dval(5), "R5 new data", rdata, dval(5));
        write_word(DEPTH - 1, dval(DEPTH - 1));

        // Exit on chip enable change
        repeat (IDLE + 1) tick();
        chk(standby == 1'b1, "R3 standby again", standby, 1);
        chip_en = 1'b0;
        tick();
        chk(standby == 1'b0, "R5 exit on chip_en", standby, 0);
        chk(rvalid == 1'b0, "R2 ce low rvalid", rvalid, 0);
        chk(rdata == dval(5), "R2 ce low holds", rdata, dval(5));

        // Synchronous mode, four-word bursts
        configure(1'b1, 2'b00);
        chip_en = 1'b1;
        repeat (2 * IDLE) tick();
        chk(standby == 1'b0, "R12 no standby in sync", standby, 0);
        for (int s = 0; s < DEPTH; s++) run_burst(s, 0, 4, -1, 0, 1'b0, 1'b0);

        // Eight-word bursts
        configure(1'b1, 2'b01);
        chk(rvalid == 1'b0, "R6 cfg clears rvalid", rvalid, 0);
        for (int s = 0; s < DEPTH; s++) run_burst(s, 1, 8, -1, 0, 1'b0, 1'b0);

        // Suspend mid-burst and hold during latency
        run_burst(2, 1, 8, 3, 3, 1'b0, 1'b0);
        run_burst(13, 1, 8, 6, 1, 1'b1, 1'b0);

        // Continuous across the top, then abort with chip enable
        configure(1'b1, 2'b11);
        run_burst(DEPTH - 2, 2, 6, 2, 2, 1'b0, 1'b1);
        chip_en = 1'b0;
        tick();
        chk(rvalid == 1'b0, "R13 abort", rvalid, 0);
        tick();
        chk(rvalid == 1'b0, "R13 stays stopped", rvalid, 0);

        // Back to asynchronous by command
        configure(1'b0, 2'b00);
        addr = AW'(9); chip_en = 1'b1;
        tick();
        chk(rdata == dval(9), "R6 async by command", rdata, dval(9));

        // Reset from synchronous mode
        configure(1'b1, 2'b00);
        addr = AW'(4); start = 1'b1;
        tick();
        start = 1'b0;
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        chk(rdata == '0, "R14 reset data", rdata, 0);
        addr = AW'(7);
        tick();
        chk(rvalid == 1'b1, "R14 async after reset", rvalid, 1);
        chk(rdata == dval(7), "R14 async data", rdata, dval(7));

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule